// File: doc/BRIEF.md
# Virtual Output Queue Ingress Buffer

This block sits on the receive side of one port of a small frame switch. Each frame arrives as a fixed number of data beats. The destination identifier is presented with the first beat. A lookup table maps that identifier to an egress port. The frame is then written into a slot of a single shared ingress memory and linked onto a logical queue kept for that egress port. There is one queue for every other port of the switch and none for the port itself, so a frame waits only behind earlier frames bound for the same egress port.

For every queue that holds at least one complete frame, the block raises a request line toward a central arbiter. When the arbiter grants a requesting port, the oldest frame of that queue is streamed beat by beat toward the crossbar, and its slot goes back to the free pool. When no slot is free, the input ready line drops, so a waiting frame is held back rather than lost. The lookup table is loaded through a small configuration write port indexed by destination identifier.

Top module: `voq_ingress_buffer`

## Requirements
- R1: After reset, in_ready is 1, arb_req is all zero and xb_valid is 0.
- R2: After reset, destination identifier d routes to egress port q + (q >= SELF_PORT ? 1 : 0), where q = d mod (NUM_PORTS-1).
- R3: A configuration write (cfg_we high for one cycle) replaces the route for cfg_did with cfg_port. A write that names SELF_PORT, or a port number of NUM_PORTS or more, is ignored and the old route stays.
- R4: arb_req[p] is 1 exactly when the queue for port p holds a complete frame and no transfer is in progress. The request appears in the cycle after the last input beat is accepted. arb_req[SELF_PORT] is never 1.
- R5: A grant on a requesting port p starts a transfer in the next cycle. xb_valid is then high for BEATS consecutive cycles, xb_port equals p, xb_data repeats the frame's beats in input order, and xb_last is high on the final beat only. xb_valid is low in the cycle after xb_last.
- R6: A grant on a port that is not requesting, or any grant while a transfer is running, has no effect. When several requesting ports are granted together, the lowest-numbered one is served.
- R7: Frames in one queue leave in the order they were accepted.
- R8: A queue whose port is not granted does not stop frames of other queues from leaving.
- R9: When all SLOTS slots are taken and no frame is being received, in_ready is 0. A held frame is accepted once a transfer completes, starting in the cycle after xb_last, and no frame is lost.
- R10: A slot freed by a finishing transfer and a slot taken by a new frame in the same cycle are both accounted for, so the pool still holds exactly SLOTS frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Route table write strobe |
| cfg_did | input | DID_W | Destination identifier to rewrite |
| cfg_port | input | PORT_W | New egress port for cfg_did |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | DATA_W | Input beat data |
| in_did | input | DID_W | Destination identifier, read with the first beat |
| arb_req | output | NUM_PORTS | Per-egress-port transfer request |
| arb_gnt | input | NUM_PORTS | Per-egress-port grant from the arbiter |
| xb_valid | output | 1 | Output beat present |
| xb_data | output | DATA_W | Output beat data |
| xb_last | output | 1 | Final beat of the frame |
| xb_port | output | PORT_W | Egress port of the frame being sent |

## Verification
Two functions can land on the same clock edge. One is the release of a slot at the end of an outgoing transfer. The other is the taking of a slot for the first beat of a new incoming frame. The bench provokes this by leaving exactly one slot free, granting a queue, and timing a new frame so that its first beat is accepted on the edge that ends the transfer. It judges the result by filling the buffer afterwards: ready must drop after exactly the right number of further frames, and every frame must then drain intact and in order, which would fail if the pool count or a reused slot were corrupted.

// File: rtl/voq_pkg.sv
`timescale 1ns/1ps
package voq_pkg;

  // Queue index of an egress port; the own port has no queue.
  function automatic int dest_to_queue(int port, int self_port);
    return (port > self_port) ? port - 1 : port;
  endfunction

  // Egress port served by a queue index.
  function automatic int queue_to_dest(int q, int self_port);
    return (q >= self_port) ? q + 1 : q;
  endfunction

  // Reset-time route for a destination identifier.
  function automatic int default_route(int did, int nports, int self_port);
    return queue_to_dest(did % (nports - 1), self_port);
  endfunction

  // Word address of one beat inside the shared memory.
  function automatic int beat_addr(int slot, int beat, int beats);
    return slot * beats + beat;
  endfunction

endpackage

// File: rtl/voq_route_table.sv
`timescale 1ns/1ps
module voq_route_table #(
  parameter int NUM_PORTS = 4,
  parameter int SELF_PORT = 0,
  parameter int DID_W     = 4,
  parameter int PORT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DID_W-1:0]  cfg_did,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [DID_W-1:0]  lk_did,
  output logic [PORT_W-1:0] lk_port
);
  import voq_pkg::*;

  localparam int ENTRIES = 1 << DID_W;

  logic [PORT_W-1:0] route_mem [ENTRIES];
  logic              cfg_accept;

  assign cfg_accept = cfg_we && (cfg_port != PORT_W'(SELF_PORT))
                      && (int'(cfg_port) < NUM_PORTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < ENTRIES; d++)
        route_mem[d] <= PORT_W'(default_route(d, NUM_PORTS, SELF_PORT));
    end else if (cfg_accept) begin
      route_mem[cfg_did] <= cfg_port;
    end
  end

  assign lk_port = route_mem[lk_did];

  // R3: no lookup ever yields the own port
  assert_route_not_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_port != PORT_W'(SELF_PORT));

endmodule

// File: rtl/voq_free_pool.sv
`timescale 1ns/1ps
module voq_free_pool #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give,
  input  logic [SLOT_W-1:0] give_slot,
  output logic [SLOT_W-1:0] top_slot,
  output logic              avail,
  output logic [CNT_W-1:0]  free_cnt
);

  logic [SLOT_W-1:0] ring [SLOTS];
  logic [SLOT_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [SLOT_W-1:0] step(logic [SLOT_W-1:0] p);
    return (int'(p) == SLOTS - 1) ? '0 : p + SLOT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ring[i] <= SLOT_W'(i);
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      free_cnt <= CNT_W'(SLOTS);
    end else begin
      if (take) rd_ptr <= step(rd_ptr);
      if (give) begin
        ring[wr_ptr] <= give_slot;
        wr_ptr       <= step(wr_ptr);
      end
      free_cnt <= free_cnt + CNT_W'(give) - CNT_W'(take);
    end
  end

  assign top_slot = ring[rd_ptr];
  assign avail    = free_cnt != '0;

  // R9: a slot is never taken from an empty pool
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> free_cnt != '0);

  // R10: a slot is never returned to a full pool
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |-> free_cnt != CNT_W'(SLOTS));

endmodule

// File: rtl/voq_queue_links.sv
`timescale 1ns/1ps
module voq_queue_links #(
  parameter int NUM_Q  = 3,
  parameter int QIDX_W = 2,
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [QIDX_W-1:0]             push_q,
  input  logic [SLOT_W-1:0]             push_slot,
  input  logic                          pop,
  input  logic [QIDX_W-1:0]             pop_q,
  output logic [NUM_Q-1:0][SLOT_W-1:0]  heads,
  output logic [NUM_Q-1:0]              nonempty
);

  logic [SLOT_W-1:0]             link [SLOTS];
  logic [NUM_Q-1:0][SLOT_W-1:0]  tails;
  logic [NUM_Q-1:0]              chain_req;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic [SLOT_W-1:0] head_r, tail_r;
    logic [CNT_W-1:0]  cnt_r;
    logic              push_here, pop_here, fresh;

    assign push_here = push && (push_q == QIDX_W'(q));
    assign pop_here  = pop  && (pop_q  == QIDX_W'(q));
    // queue is empty once any same-cycle pop is applied
    assign fresh     = (cnt_r == '0) || (pop_here && cnt_r == CNT_W'(1));
    assign chain_req[q] = push_here && !fresh;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        head_r <= '0;
        tail_r <= '0;
        cnt_r  <= '0;
      end else begin
        cnt_r <= cnt_r + CNT_W'(push_here) - CNT_W'(pop_here);
        if (push_here) tail_r <= push_slot;
        if (push_here && fresh) head_r <= push_slot;
        else if (pop_here)      head_r <= link[head_r];
      end
    end

    assign heads[q]    = head_r;
    assign tails[q]    = tail_r;
    assign nonempty[q] = cnt_r != '0;
  end

  always_ff @(posedge clk) begin
    if (|chain_req) link[tails[push_q]] <= push_slot;
  end

  // R6: only a queue with a frame is ever popped
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty[pop_q]);

endmodule

// File: rtl/voq_ingress_buffer.sv
`timescale 1ns/1ps
module voq_ingress_buffer #(
  parameter int NUM_PORTS = 4,
  parameter int SELF_PORT = 0,
  parameter int DID_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SLOTS     = 8,
  parameter int BEATS     = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DID_W-1:0]     cfg_did,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [DID_W-1:0]     in_did,
  output logic [NUM_PORTS-1:0] arb_req,
  input  logic [NUM_PORTS-1:0] arb_gnt,
  output logic                 xb_valid,
  output logic [DATA_W-1:0]    xb_data,
  output logic                 xb_last,
  output logic [PORT_W-1:0]    xb_port
);
  import voq_pkg::*;

  localparam int NUM_Q  = NUM_PORTS - 1;
  localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int WORDS  = SLOTS * BEATS;
  localparam int ADDR_W = $clog2(WORDS);

  // ---------------- shared frame memory ----------------
  logic [DATA_W-1:0] frame_mem [WORDS];

  // ---------------- named internal events ----------------
  logic alloc_evt, release_evt, enqueue_evt, grant_evt, in_fire;

  // ---------------- receive side state ----------------
  logic              wr_active;
  logic [BEAT_W-1:0] wr_beat;
  logic [SLOT_W-1:0] wr_slot;
  logic [QIDX_W-1:0] wr_q;

  // ---------------- transmit side state ----------------
  logic              rd_active;
  logic [BEAT_W-1:0] rd_beat;
  logic [SLOT_W-1:0] rd_slot;
  logic [PORT_W-1:0] rd_port;

  // ---------------- sub-block wiring ----------------
  logic [PORT_W-1:0]            lk_port;
  logic [QIDX_W-1:0]            lk_q;
  logic [SLOT_W-1:0]            pool_top;
  logic                         pool_avail;
  logic [CNT_W-1:0]             pool_cnt;
  logic [NUM_Q-1:0][SLOT_W-1:0] q_heads;
  logic [NUM_Q-1:0]             q_nonempty;
  logic [SLOT_W-1:0]            cur_slot;
  logic [QIDX_W-1:0]            cur_q;
  logic [QIDX_W-1:0]            pop_q;
  logic [NUM_PORTS-1:0]         gnt_hit;
  logic [PORT_W-1:0]            grant_port;
  logic [ADDR_W-1:0]            wr_addr, rd_addr;

  voq_route_table #(
    .NUM_PORTS(NUM_PORTS), .SELF_PORT(SELF_PORT), .DID_W(DID_W), .PORT_W(PORT_W)
  ) i_route (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_did(cfg_did),
    .cfg_port(cfg_port), .lk_did(in_did), .lk_port(lk_port)
  );

  voq_free_pool #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) i_pool (
    .clk(clk), .rst_n(rst_n), .take(alloc_evt), .give(release_evt),
    .give_slot(rd_slot), .top_slot(pool_top), .avail(pool_avail),
    .free_cnt(pool_cnt)
  );

  voq_queue_links #(
    .NUM_Q(NUM_Q), .QIDX_W(QIDX_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) i_links (
    .clk(clk), .rst_n(rst_n), .push(enqueue_evt), .push_q(cur_q),
    .push_slot(cur_slot), .pop(grant_evt), .pop_q(pop_q),
    .heads(q_heads), .nonempty(q_nonempty)
  );

  // ---------------- receive path ----------------
  assign in_ready    = wr_active || pool_avail;
  assign in_fire     = in_valid && in_ready;
  assign alloc_evt   = in_fire && !wr_active;
  assign enqueue_evt = in_fire && (int'(wr_beat) == BEATS - 1);
  assign lk_q        = QIDX_W'(dest_to_queue(int'(lk_port), SELF_PORT));
  assign cur_slot    = wr_active ? wr_slot : pool_top;
  assign cur_q       = wr_active ? wr_q : lk_q;
  assign wr_addr     = ADDR_W'(beat_addr(int'(cur_slot), int'(wr_beat), BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      wr_beat   <= '0;
      wr_slot   <= '0;
      wr_q      <= '0;
    end else if (in_fire) begin
      if (enqueue_evt) begin
        wr_active <= 1'b0;
        wr_beat   <= '0;
      end else begin
        wr_active <= 1'b1;
        wr_beat   <= wr_beat + BEAT_W'(1);
      end
      if (alloc_evt) begin
        wr_slot <= pool_top;
        wr_q    <= lk_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) frame_mem[wr_addr] <= in_data;
  end

  // ---------------- request and grant ----------------
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
    if (p == SELF_PORT) begin : g_self
      assign arb_req[p] = 1'b0;
    end else begin : g_other
      assign arb_req[p] = q_nonempty[dest_to_queue(p, SELF_PORT)] && !rd_active;
    end
  end

  assign gnt_hit   = arb_gnt & arb_req;
  assign grant_evt = |gnt_hit;

  always_comb begin
    grant_port = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--)
      if (gnt_hit[p]) grant_port = PORT_W'(p);
  end

  assign pop_q = QIDX_W'(dest_to_queue(int'(grant_port), SELF_PORT));

  // ---------------- transmit path ----------------
  assign release_evt = rd_active && (int'(rd_beat) == BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_beat   <= '0;
      rd_slot   <= '0;
      rd_port   <= '0;
    end else if (grant_evt) begin
      rd_active <= 1'b1;
      rd_beat   <= '0;
      rd_slot   <= q_heads[pop_q];
      rd_port   <= grant_port;
    end else if (release_evt) begin
      rd_active <= 1'b0;
      rd_beat   <= '0;
    end else if (rd_active) begin
      rd_beat   <= rd_beat + BEAT_W'(1);
    end
  end

  assign rd_addr  = ADDR_W'(beat_addr(int'(rd_slot), int'(rd_beat), BEATS));
  assign xb_valid = rd_active;
  assign xb_last  = release_evt;
  assign xb_data  = frame_mem[rd_addr];
  assign xb_port  = rd_port;

  // ---------------- assertions ----------------
  // R5: a taken grant opens a transfer for that port on the next cycle
  assert_grant_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> xb_valid && (xb_port == $past(grant_port)));

  // R5: the port stays fixed and valid stays high until the last beat
  assert_port_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_valid && !xb_last) |=> xb_valid && $stable(xb_port));

  // R5: one idle cycle follows every final beat
  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xb_last |=> !xb_valid);

  // R9: a frame in progress always has its slot, so ready never falls mid-frame
  assert_ready_mid_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !enqueue_evt) |=> in_ready);

endmodule

// File: tb/test_voq_ingress_buffer.sv
`timescale 1ns/1ps
module test_voq_ingress_buffer;
  localparam int NP = 4, SELF = 0, DW = 4, DATW = 16, SL = 8, BT = 4, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [DW-1:0] cfg_did = '0;
  logic [PW-1:0] cfg_port = '0;
  logic in_valid = 1'b0, in_ready;
  logic [DATW-1:0] in_data = '0;
  logic [DW-1:0] in_did = '0;
  logic [NP-1:0] arb_req, arb_gnt = '0;
  logic xb_valid, xb_last;
  logic [DATW-1:0] xb_data;
  logic [PW-1:0] xb_port;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  voq_ingress_buffer #(.NUM_PORTS(NP), .SELF_PORT(SELF), .DID_W(DW), .DATA_W(DATW),
                       .SLOTS(SL), .BEATS(BT)) i_voq_ingress_buffer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_did(cfg_did), .cfg_port(cfg_port),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_did(in_did),
    .arb_req(arb_req), .arb_gnt(arb_gnt), .xb_valid(xb_valid), .xb_data(xb_data),
    .xb_last(xb_last), .xb_port(xb_port));

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int route_of(int did);
    int q = did % (NP - 1);
    return (q >= SELF) ? q + 1 : q;
  endfunction

  function automatic logic [DATW-1:0] word(int tag, int b);
    return {8'(tag), 8'(b)};
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic send_frame(int did, int tag);
    for (int b = 0; b < BT; b++) begin
      in_valid = 1'b1; in_did = DW'(did); in_data = word(tag, b);
      while (!in_ready) begin @(posedge clk); @(negedge clk); end
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(int did, int port);
    cfg_we = 1'b1; cfg_did = DW'(did); cfg_port = PW'(port);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // grant with gmask, expect port p to stream frame tag; busy_mask held during beats
  task automatic collect(int p, int tag, logic [NP-1:0] gmask, logic [NP-1:0] busy_mask);
    chk(arb_req[p] == 1'b1, "R4 request before grant", arb_req, 1 << p);
    arb_gnt = gmask;
    @(posedge clk); @(negedge clk);
    arb_gnt = busy_mask;
    for (int b = 0; b < BT; b++) begin
      chk(xb_valid == 1'b1, "R5 valid during transfer", xb_valid, 1);
      chk(xb_port == PW'(p), "R5/R6 port of transfer", xb_port, p);
      chk(xb_data == word(tag, b), "R5/R7 beat data", xb_data, word(tag, b));
      chk(xb_last == (b == BT - 1), "R5 last flag", xb_last, b == BT - 1);
      chk(arb_req == '0, "R4 no request while busy", arb_req, 0);
      @(negedge clk);
    end
    arb_gnt = '0;
    chk(xb_valid == 1'b0, "R5 idle after last", xb_valid, 0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(arb_req == '0, "R1 no request after reset", arb_req, 0);
    chk(xb_valid == 1'b0, "R1 no output after reset", xb_valid, 0);
  endtask

  task automatic t_default_route();
    for (int d = 0; d < 3; d++) begin
      send_frame(d, 16 + d);
      chk(arb_req == NP'(1 << route_of(d)), "R2 default route request", arb_req, 1 << route_of(d));
      // R6: grant to a port without a request does nothing
      arb_gnt = NP'(1 << ((route_of(d) % (NP - 1)) + 1));
      @(posedge clk); @(negedge clk);
      arb_gnt = '0;
      chk(xb_valid == 1'b0, "R6 stray grant ignored", xb_valid, 0);
      collect(route_of(d), 16 + d, NP'(1 << route_of(d)), '0);
    end
  endtask

  task automatic t_config();
    cfg_write(5, 3);
    cfg_write(6, SELF);  // R3: own port rejected, did 6 keeps default route
    send_frame(5, 48);
    send_frame(6, 49);
    chk(arb_req == NP'((1 << 3) | (1 << route_of(6))), "R3 rewritten and kept routes",
        arb_req, (1 << 3) | (1 << route_of(6)));
    // R6: both granted, lowest port served; grant during transfer ignored
    collect(route_of(6), 49, NP'((1 << 3) | (1 << route_of(6))), NP'(1 << 3));
    collect(3, 48, NP'(1 << 3), '0);
  endtask

  task automatic t_hol();
    send_frame(0, 64);   // port 1
    send_frame(1, 65);   // port 2
    send_frame(0, 66);   // port 1
    chk(arb_req == 4'b0110, "R8 both queues request", arb_req, 6);
    collect(2, 65, 4'b0100, 4'b0010);   // R8: port 2 leaves while port 1 waits
    chk(arb_req == 4'b0010, "R8 port 1 still waiting", arb_req, 2);
    collect(1, 64, 4'b0010, '0);        // R7 order
    collect(1, 66, 4'b0010, '0);
  endtask

  task automatic t_full();
    for (int i = 0; i < SL; i++) send_frame(2, 32 + i);
    chk(in_ready == 1'b0, "R9 ready low when full", in_ready, 0);
    in_valid = 1'b1; in_did = DW'(2); in_data = word(32 + SL, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(in_ready == 1'b0, "R9 held frame waits", in_ready, 0);
    end
    fork
      collect(route_of(2), 32, NP'(1 << route_of(2)), '0);
      send_frame(2, 32 + SL);
    join
    for (int i = 1; i <= SL; i++) collect(route_of(2), 32 + i, NP'(1 << route_of(2)), '0);
    chk(arb_req == '0, "R9 all frames drained", arb_req, 0);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < SL - 1; i++) send_frame(0, 80 + i);
    fork
      collect(1, 80, 4'b0010, '0);
      begin repeat (BT) @(negedge clk); send_frame(1, 96); end
    join
    chk(in_ready == 1'b1, "R10 one slot left after swap", in_ready, 1);
    send_frame(0, 97);
    chk(in_ready == 1'b0, "R10 pool full after swap", in_ready, 0);
    collect(2, 96, 4'b0100, '0);
    for (int i = 1; i < SL - 1; i++) collect(1, 80 + i, 4'b0010, '0);
    collect(1, 97, 4'b0010, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_default_route();
    t_config();
    t_hol();
    t_full();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule